// File: doc/BRIEF.md
# Thread-Tagged Direct-Mapped Branch Target Buffer

This block keeps one predicted branch target for each slot of a direct-mapped table that several hardware threads share. On the lookup side the fetch stage presents a program counter and a thread number. Within the same cycle the block says whether a usable target is stored and, if one is, returns it. On the update side the branch-resolution logic writes a program counter, a thread number and a target. That write replaces the slot the pair maps to, whatever the slot held before.

The thread number enters the table in two ways. It is folded into the slot selection, so the same address from different threads usually lands in different slots. It is also stored beside the target, so a slot written by one thread never produces a hit for another. The entry count, tag width, instruction-alignment shift, thread count and data widths are all parameters. The entry count must be a power of two, and elaboration stops if it is not.

A synchronous reset invalidates the whole table in one cycle.

Top module: `btb_mt`

## Requirements
- R1: The slot index is `((pc >> ALIGN_SH) XOR (tid << (log2(ENTRIES) - log2(THREADS))))`, keeping the low log2(ENTRIES) bits. With the defaults (64 entries, shift 2, 4 threads) the index is `pc[7:2] ^ {tid, 4'b0}`.
- R2: The tag is `(pc >> (ALIGN_SH + log2(ENTRIES)))`, keeping the low TAG_W bits. With the defaults this is `pc[19:8]`.
- R3: `lk_hit` is 1 only when the indexed slot is valid, its stored tag equals the lookup tag, and its stored thread number equals `lk_tid`.
- R4: When `lk_hit` is 0, `lk_target` is all zeros. A stored target of zero is returned with `lk_hit` = 1.
- R5: When `up_en` is 1 and `rst` is 0 on a rising edge, the indexed slot is overwritten with the thread, the tag and the target, and becomes valid. A lookup of the same pc and tid in the next cycle returns that target.
- R6: Lookup is combinational from the stored state. A lookup in the same cycle as a write to its slot sees the contents from before that write.
- R7: While `rst` is 1 on a rising edge, every slot becomes invalid and any update in that cycle is discarded. The lookup after such an edge misses.
- R8: Two pc/tid pairs that map to the same slot evict each other, the last write wins. An entry written by one thread never hits for a different thread.
- R9: Program counter bits above the tag field and below the alignment shift have no effect on the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high invalidate-all |
| lk_pc | input | PC_W | Lookup program counter |
| lk_tid | input | TID_W | Lookup thread number |
| lk_hit | output | 1 | Stored target found for this pc and thread |
| lk_target | output | TGT_W | Stored target, zero on a miss |
| up_en | input | 1 | Write the update triple this cycle |
| up_pc | input | PC_W | Program counter of the resolved branch |
| up_tid | input | TID_W | Thread of the resolved branch |
| up_target | input | TGT_W | Target to store |

## Verification
Several properties are checked on every cycle. An update must be visible on the next cycle's lookup of the same pc and thread. A reset edge must leave the next lookup missing. A miss must drive a zero target. The valid set may change only through a write or a reset, and it may gain at most one slot per cycle. Other behaviour can only be shown by scenarios the bench constructs. These include the placement of the thread number in the index, demonstrated by cross-thread aliasing into one slot. They also include the tag boundaries, the old-data result of a same-cycle read and write, a stored zero target, and reset winning over a simultaneous update.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // True when v is a nonzero power of two
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Width of a thread-number field; at least one bit
    function automatic int unsigned tid_width(input int unsigned threads);
        return (threads > 1) ? $clog2(threads) : 1;
    endfunction

    // Bit position at which the thread number is mixed into the index.
    // A value equal to idx_w shifts the thread term out entirely.
    function automatic int unsigned tid_mix_pos(input int unsigned idx_w,
                                                input int unsigned threads);
        return idx_w - $clog2(threads);
    endfunction

    // Which port of the table a hash unit serves
    typedef enum logic {
        PORT_LOOKUP = 1'b0,
        PORT_UPDATE = 1'b1
    } btb_port_e;

endpackage

// File: rtl/btb_hash.sv
module btb_hash #(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned IDX_W    = 6,
    parameter int unsigned TID_W    = 2,
    parameter int unsigned THREADS  = 4,
    parameter int unsigned ALIGN_SH = 2,
    parameter int unsigned TAG_W    = 12
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TID_W-1:0] tid,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    import btb_pkg::*;

    localparam int unsigned MIX_POS = tid_mix_pos(IDX_W, THREADS);
    localparam int unsigned TAG_SH  = ALIGN_SH + IDX_W;

    logic [IDX_W-1:0] pc_part;
    logic [IDX_W-1:0] tid_part;

    always_comb begin
        pc_part  = IDX_W'(pc >> ALIGN_SH);
        // with one thread MIX_POS equals IDX_W and the term is zero
        tid_part = IDX_W'({{IDX_W{1'b0}}, tid} << MIX_POS);
        idx      = pc_part ^ tid_part;
        tag      = TAG_W'(pc >> TAG_SH);
    end

endmodule

// File: rtl/btb_store.sv
module btb_store #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned TAG_W   = 12,
    parameter int unsigned TID_W   = 2,
    parameter int unsigned TGT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TID_W-1:0] rd_tid,
    output logic [TGT_W-1:0] rd_tgt
);
    typedef struct packed {
        logic [TID_W-1:0] tid;
        logic [TAG_W-1:0] tag;
        logic [TGT_W-1:0] tgt;
    } slot_t;

    logic [ENTRIES-1:0] valid_q;
    slot_t              slot_q [ENTRIES];
    slot_t              rd_slot;

    // valid bits: reset wins over a write in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // payload needs no reset; it is only seen through a valid bit
    always_ff @(posedge clk) begin
        if (wr_en && !rst) begin
            slot_q[wr_idx] <= '{tid: wr_tid, tag: wr_tag, tgt: wr_tgt};
        end
    end

    always_comb begin
        rd_slot  = slot_q[rd_idx];
        rd_valid = valid_q[rd_idx];
        rd_tag   = rd_slot.tag;
        rd_tid   = rd_slot.tid;
        rd_tgt   = rd_slot.tgt;
    end

    AST_VALID_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> (valid_q == $past(valid_q))); // R5
    AST_ONE_SLOT_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(valid_q) <= $countones($past(valid_q)) + 1)); // R5
    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> valid_q[$past(wr_idx)]); // R5

endmodule

// File: rtl/btb_match.sv
module btb_match #(
    parameter int unsigned TAG_W = 12,
    parameter int unsigned TID_W = 2,
    parameter int unsigned TGT_W = 32
) (
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TID_W-1:0] slot_tid,
    input  logic [TGT_W-1:0] slot_tgt,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TID_W-1:0] req_tid,
    output logic             hit,
    output logic [TGT_W-1:0] target
);
    logic tag_eq;
    logic tid_eq;

    always_comb begin
        tag_eq = (slot_tag == req_tag);
        tid_eq = (slot_tid == req_tid);
        hit    = slot_valid && tag_eq && tid_eq;
        target = hit ? slot_tgt : '0;
    end

endmodule

// File: rtl/btb_mt.sv
module btb_mt #(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned TGT_W    = 32,
    parameter int unsigned ENTRIES  = 64,
    parameter int unsigned TAG_W    = 12,
    parameter int unsigned ALIGN_SH = 2,
    parameter int unsigned THREADS  = 4,
    parameter int unsigned TID_W    = btb_pkg::tid_width(THREADS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic [TID_W-1:0] lk_tid,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic             up_en,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [TID_W-1:0] up_tid,
    input  logic [TGT_W-1:0] up_target
);
    import btb_pkg::*;

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    generate
        if (!is_pow2(ENTRIES) || ENTRIES < 2) begin : g_bad_entries
            $error("btb_mt: ENTRIES must be a power of two and at least 2");
        end
        if (THREADS < 1 || THREADS > ENTRIES) begin : g_bad_threads
            $error("btb_mt: THREADS must lie between 1 and ENTRIES");
        end
    endgenerate

    // one hash unit per port
    logic [PC_W-1:0]  h_pc  [2];
    logic [TID_W-1:0] h_tid [2];
    logic [IDX_W-1:0] h_idx [2];
    logic [TAG_W-1:0] h_tag [2];

    always_comb begin
        h_pc[PORT_LOOKUP]  = lk_pc;
        h_tid[PORT_LOOKUP] = lk_tid;
        h_pc[PORT_UPDATE]  = up_pc;
        h_tid[PORT_UPDATE] = up_tid;
    end

    for (genvar p = 0; p < 2; p++) begin : g_hash
        btb_hash #(
            .PC_W(PC_W), .IDX_W(IDX_W), .TID_W(TID_W), .THREADS(THREADS),
            .ALIGN_SH(ALIGN_SH), .TAG_W(TAG_W)
        ) i_hash (
            .pc(h_pc[p]), .tid(h_tid[p]), .idx(h_idx[p]), .tag(h_tag[p])
        );
    end

    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [TID_W-1:0] rd_tid;
    logic [TGT_W-1:0] rd_tgt;

    btb_store #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .TID_W(TID_W), .TGT_W(TGT_W)
    ) i_store (
        .clk(clk), .rst(rst),
        .wr_en(up_en), .wr_idx(h_idx[PORT_UPDATE]), .wr_tag(h_tag[PORT_UPDATE]),
        .wr_tid(up_tid), .wr_tgt(up_target),
        .rd_idx(h_idx[PORT_LOOKUP]),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tid(rd_tid), .rd_tgt(rd_tgt)
    );

    btb_match #(.TAG_W(TAG_W), .TID_W(TID_W), .TGT_W(TGT_W)) i_match (
        .slot_valid(rd_valid), .slot_tag(rd_tag), .slot_tid(rd_tid),
        .slot_tgt(rd_tgt), .req_tag(h_tag[PORT_LOOKUP]), .req_tid(lk_tid),
        .hit(lk_hit), .target(lk_target)
    );

    AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        ($past(up_en) && !$past(rst) && lk_pc == $past(up_pc) && lk_tid == $past(up_tid))
        |-> (lk_hit && lk_target == $past(up_target))); // R5
    AST_RESET_EMPTIES: assert property (@(posedge clk)
        rst |=> !lk_hit); // R7
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_target == '0)); // R4

endmodule

// File: tb/test_btb_mt.sv
module test_btb_mt;
    localparam int PC_W = 32, TGT_W = 32, TID_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PC_W-1:0]  lk_pc = '0;
    logic [TID_W-1:0] lk_tid = '0;
    logic             lk_hit;
    logic [TGT_W-1:0] lk_target;
    logic             up_en = 1'b0;
    logic [PC_W-1:0]  up_pc = '0;
    logic [TID_W-1:0] up_tid = '0;
    logic [TGT_W-1:0] up_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    btb_mt i_btb_mt (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_tid(lk_tid),
        .lk_hit(lk_hit), .lk_target(lk_target), .up_en(up_en),
        .up_pc(up_pc), .up_tid(up_tid), .up_target(up_target)
    );

    // reference model built from the requirements
    bit        m_valid [64];
    bit [11:0] m_tag   [64];
    bit [1:0]  m_tid   [64];
    bit [31:0] m_tgt   [64];

    function automatic int ref_idx(bit [31:0] pc, bit [1:0] tid); // R1
        return int'((pc >> 2) ^ (32'(tid) << 4)) & 63;
    endfunction

    function automatic bit [11:0] ref_tag(bit [31:0] pc); // R2
        return pc[19:8];
    endfunction

    function automatic bit [31:0] make_pc(bit [5:0] ix, bit [11:0] tg, bit [11:0] hi,
                                          bit [1:0] lo);
        return {hi, tg, ix, lo};
    endfunction

    task automatic check(string req, bit exp_hit, bit [31:0] exp_tgt);
        checks++;
        if (lk_hit !== exp_hit || lk_target !== exp_tgt) begin
            errors++;
            $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
                     req, lk_hit, lk_target, exp_hit, exp_tgt);
        end
    endtask

    task automatic check_model(string req);
        int i;
        bit h;
        i = ref_idx(lk_pc, lk_tid);
        h = m_valid[i] && m_tag[i] == ref_tag(lk_pc) && m_tid[i] == lk_tid;
        check(req, h, h ? m_tgt[i] : 32'h0);
    endtask

    // effect of the coming rising edge on the model
    task automatic commit();
        if (rst) begin
            for (int i = 0; i < 64; i++) m_valid[i] = 1'b0;
        end else if (up_en) begin
            int i;
            i = ref_idx(up_pc, up_tid);
            m_valid[i] = 1'b1;
            m_tag[i]   = ref_tag(up_pc);
            m_tid[i]   = up_tid;
            m_tgt[i]   = up_target;
        end
    endtask

    // drive after a falling edge, settle, leave sampling to the caller
    task automatic drive(bit r, bit [31:0] lpc, bit [1:0] ltid,
                         bit ue, bit [31:0] upc, bit [1:0] utid, bit [31:0] utgt);
        @(negedge clk);
        rst = r; lk_pc = lpc; lk_tid = ltid;
        up_en = ue; up_pc = upc; up_tid = utid; up_target = utgt;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        bit [31:0] pa, pb, pq, pz;
        int unsigned seed;
        seed = 32'd7;
        void'($urandom(seed));
        for (int i = 0; i < 64; i++) m_valid[i] = 1'b0;

        drive(1, 0, 0, 0, 0, 0, 0); commit();
        drive(1, 0, 0, 0, 0, 0, 0); commit();
        // R7 reset state
        drive(0, make_pc(6'd5, 12'h123, 0, 0), 2'd1, 0, 0, 0, 0);
        check("R7 reset state", 1'b0, 32'h0); commit();

        // R6 same-cycle write and read of one slot returns old contents
        pa = make_pc(6'd9, 12'h0AB, 12'h000, 2'b00);
        drive(0, pa, 2'd1, 1, pa, 2'd1, 32'hCAFE_0001);
        check("R6 read during write", 1'b0, 32'h0); commit();
        // R5 visible next cycle
        drive(0, pa, 2'd1, 0, 0, 0, 0);
        check("R5 write visible", 1'b1, 32'hCAFE_0001); commit();
        // R8 / R3 other thread misses
        drive(0, pa, 2'd2, 0, 0, 0, 0);
        check("R8 other thread misses", 1'b0, 32'h0); commit();
        // R9 upper and low pc bits ignored
        drive(0, make_pc(6'd9, 12'h0AB, 12'hFA5, 2'b11), 2'd1, 0, 0, 0, 0);
        check("R9 outside bits ignored", 1'b1, 32'hCAFE_0001); commit();
        // R2 lowest tag bit matters
        drive(0, make_pc(6'd9, 12'h0AA, 12'h000, 2'b00), 2'd1, 0, 0, 0, 0);
        check("R2 tag bit 0 differs", 1'b0, 32'h0); commit();
        drive(0, make_pc(6'd9, 12'h8AB, 12'h000, 2'b00), 2'd1, 0, 0, 0, 0);
        check("R2 tag top bit differs", 1'b0, 32'h0); commit();
        // R1 thread 1 at pc index 9 uses slot 9^16=25; pc index 25 thread 0 aliases it
        pq = make_pc(6'd25, 12'h0AB, 12'h000, 2'b00);
        drive(0, pq, 2'd0, 1, pq, 2'd0, 32'h1111_2222); commit();
        drive(0, pa, 2'd1, 0, 0, 0, 0);
        check("R1 thread mix aliases slot", 1'b0, 32'h0); commit();
        drive(0, pq, 2'd0, 0, 0, 0, 0);
        check("R1 alias entry hits", 1'b1, 32'h1111_2222); commit();
        // R8 eviction within one thread by a different tag
        pb = make_pc(6'd25, 12'h777, 12'h000, 2'b00);
        drive(0, pb, 2'd0, 1, pb, 2'd0, 32'h3333_4444); commit();
        drive(0, pq, 2'd0, 0, 0, 0, 0);
        check("R8 evicted entry misses", 1'b0, 32'h0); commit();
        drive(0, pb, 2'd0, 0, 0, 0, 0);
        check("R8 last write wins", 1'b1, 32'h3333_4444); commit();
        // R4 stored zero target still reports a hit
        pz = make_pc(6'd40, 12'h055, 12'h000, 2'b00);
        drive(0, pz, 2'd3, 1, pz, 2'd3, 32'h0); commit();
        drive(0, pz, 2'd3, 0, 0, 0, 0);
        check("R4 zero target hit", 1'b1, 32'h0); commit();
        // R7 reset discards a simultaneous update and empties the table
        drive(1, pb, 2'd0, 1, pa, 2'd1, 32'h5555_6666); commit();
        drive(0, pa, 2'd1, 0, 0, 0, 0);
        check("R7 update during reset dropped", 1'b0, 32'h0); commit();
        drive(0, pb, 2'd0, 0, 0, 0, 0);
        check("R7 old entry gone", 1'b0, 32'h0); commit();

        // random traffic over a narrow tag pool to get hits and evictions
        for (int n = 0; n < 4000; n++) begin
            bit [31:0] lp, upp;
            bit [1:0] lt, ut;
            lp  = make_pc(6'($urandom_range(0, 15)), 12'($urandom_range(0, 3)),
                          12'($urandom), 2'($urandom));
            upp = make_pc(6'($urandom_range(0, 15)), 12'($urandom_range(0, 3)),
                          12'($urandom), 2'($urandom));
            lt = 2'($urandom);
            ut = 2'($urandom);
            drive(($urandom_range(0, 199) == 0), lp, lt,
                  ($urandom_range(0, 2) == 0), upp, ut, $urandom);
            check_model("R3 R4 R5 R8 random lookup");
            commit();
        end

        finish_run();
    end
endmodule